// File: doc/BRIEF.md
# Load/Store Ordering Queue with Address Disambiguation

This block keeps the memory operations of an out-of-order core in program order. Each load or store takes a slot at the tail when it is dispatched. Its effective address arrives later, once the register operands that form it are available. The queue then compares addresses against older stores and decides which operation may use the single data-cache port in each cycle.

A load goes to the cache only when it is certain not to read a location that an older store will write. This means every older store must already have an address, and none of those addresses may fall in the same 32-bit word. A store never goes to memory speculatively. It leaves only when it is at the head of the queue and the commit logic says it is committing, because a write to memory cannot be undone if an older instruction faults.

A branch mispredict flushes every entry younger than a given slot. Entries leave from the head in order: an issued load leaves as soon as it reaches the head, and a committed store leaves when it is sent to the cache.

Top module: `lsq_disambig`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `alloc_idx` is 0, and `cache_valid` stays 0 even with `ld_req` or `st_commit` high.
- R2: Allocation takes the tail slot, reported on `alloc_idx` before the edge. Slots advance by one, modulo 8, in program order. With 8 live entries `full` is 1, and an allocation in that state is ignored: `alloc_idx` and `full` are unchanged.
- R3: A load is not sent to the cache while any older live store has no address.
- R4: A load is not sent while any older store has the same word address, meaning bits 31:2 are equal, even when the byte offsets differ. If all older stores have known addresses in other words, the load may issue before those stores commit.
- R5: Stores younger than a load never hold that load back.
- R6: A load is sent only while `ld_req` is 1. Among eligible loads, the oldest one (the nearest to the head) is granted, and it is granted only once. A grant is reported as `cache_valid`=1 and `cache_we`=0, with the slot on `cache_tag` and the address on `cache_addr`.
- R7: A store is sent only when it is at the head, its address is known, and `st_commit` is 1. It is then reported as `cache_valid`=1 and `cache_we`=1. In that cycle it takes the port ahead of any eligible load.
- R8: With `flush_valid` set, all entries younger than `flush_idx` are dropped and the next allocation uses `flush_idx`+1. No cache request is made in the flush cycle, and a dropped load is never sent afterwards. `flush_idx` must name a live entry.
- R9: Entries retire from the head in order, one per cycle. An issued load retires the cycle after its grant if it is at the head. A store retires in its commit cycle. Each retirement frees a slot.
- R10: A load whose address has not been written is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one entry at the tail |
| alloc_is_store | input | 1 | 1 = the new entry is a store, 0 = load |
| alloc_idx | output | 3 | Slot the next allocation will take |
| full | output | 1 | All slots live |
| addr_valid | input | 1 | Effective address writeback |
| addr_idx | input | 3 | Slot receiving the address |
| addr_val | input | 32 | Effective address |
| ld_req | input | 1 | Cache port offered to loads this cycle |
| st_commit | input | 1 | Store at the head is committing |
| flush_valid | input | 1 | Drop entries younger than `flush_idx` |
| flush_idx | input | 3 | Youngest surviving slot |
| cache_valid | output | 1 | Cache request this cycle |
| cache_we | output | 1 | 1 = store write, 0 = load read |
| cache_addr | output | 32 | Request address |
| cache_tag | output | 3 | Queue slot of the request |

## Verification
The assertions check a set of rules on every cycle. A store reaches the cache only at the head and under commit. A load grant needs `ld_req` and a known, not yet issued address. Nothing is sent during a flush. The tail lands just past the flush slot, the occupancy never exceeds the depth, and a full queue stays full without a retirement. The ordering rules themselves can only be shown by the bench's scenarios. These are the word-granular address match, the blocking by an unknown older store, the oldest-first choice across a wrapped queue, and store-over-load priority. The bench sweeps load offsets around a store address and drains a full, wrapped queue to show them.

// File: rtl/lsq_disambig.sv
module lsq_disambig #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int WB    = 2,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic          alloc_is_store,
  output logic [IW-1:0] alloc_idx,
  output logic          full,
  input  logic          addr_valid,
  input  logic [IW-1:0] addr_idx,
  input  logic [AW-1:0] addr_val,
  input  logic          ld_req,
  input  logic          st_commit,
  input  logic          flush_valid,
  input  logic [IW-1:0] flush_idx,
  output logic          cache_valid,
  output logic          cache_we,
  output logic [AW-1:0] cache_addr,
  output logic [IW-1:0] cache_tag
);

  logic [DEPTH-1:0] live, is_st, known, done;
  logic [AW-1:0]    adr [DEPTH];
  logic [IW-1:0]    head, tail;
  logic [IW:0]      cnt;
  logic [DEPTH-1:0] ld_ok;
  logic             ld_hit, st_go, ld_go, push, pop;
  logic [IW-1:0]    ld_sel;

  always_comb begin
    logic [IW-1:0] ai, aj, idx;
    ld_ok  = '0;
    ld_hit = 1'b0;
    ld_sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      ai = IW'(i) - head;
      ld_ok[i] = live[i] & ~is_st[i] & known[i] & ~done[i];
      for (int j = 0; j < DEPTH; j++) begin
        aj = IW'(j) - head;
        if (live[j] && is_st[j] && aj < ai &&
            (!known[j] || adr[j][AW-1:WB] == adr[i][AW-1:WB]))
          ld_ok[i] = 1'b0;
      end
    end
    for (int k = DEPTH-1; k >= 0; k--) begin
      idx = head + IW'(k);
      if (ld_ok[idx]) begin
        ld_hit = 1'b1;
        ld_sel = idx;
      end
    end
  end

  assign st_go       = ~flush_valid & st_commit & live[head] & is_st[head] & known[head];
  assign ld_go       = ~flush_valid & ld_req & ld_hit & ~st_go;
  assign cache_valid = st_go | ld_go;
  assign cache_we    = st_go;
  assign cache_tag   = st_go ? head : ld_sel;
  assign cache_addr  = adr[cache_tag];
  assign full        = (cnt == (IW+1)'(DEPTH));
  assign alloc_idx   = tail;
  assign push        = alloc_valid & ~full & ~flush_valid;
  assign pop         = ~flush_valid & ((live[head] & ~is_st[head] & done[head]) | st_go);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live  <= '0;
      is_st <= '0;
      known <= '0;
      done  <= '0;
      head  <= '0;
      tail  <= '0;
      cnt   <= '0;
    end else begin
      if (addr_valid && live[addr_idx]) begin
        known[addr_idx] <= 1'b1;
        adr[addr_idx]   <= addr_val;
      end
      if (ld_go) done[ld_sel] <= 1'b1;
      if (flush_valid) begin
        for (int i = 0; i < DEPTH; i++)
          if ((IW'(i) - head) > (flush_idx - head)) live[i] <= 1'b0;
        tail <= flush_idx + 1'b1;
        cnt  <= {1'b0, flush_idx - head} + 1'b1;
      end else begin
        if (push) begin
          live[tail]  <= 1'b1;
          is_st[tail] <= alloc_is_store;
          known[tail] <= 1'b0;
          done[tail]  <= 1'b0;
          tail        <= tail + 1'b1;
        end
        if (pop) begin
          live[head] <= 1'b0;
          head       <= head + 1'b1;
        end
        cnt <= cnt + (IW+1)'(push) - (IW+1)'(pop);
      end
    end
  end

  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (IW+1)'(DEPTH));

  a_r7_store_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_valid && cache_we) |-> (st_commit && cache_tag == head));

  a_r6_load_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_valid && !cache_we) |-> ld_req);

  a_r10_load_addr_known: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_valid && !cache_we) |-> (known[cache_tag] && !done[cache_tag]));

  a_r8_quiet_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !cache_valid);

  a_r8_flush_tail: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (tail == IW'($past(flush_idx) + 1'b1)));

  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush_valid) |=> full);

endmodule

// File: tb/tb_lsq_disambig.sv
module tb_lsq_disambig;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        alloc_valid = 0, alloc_is_store = 0, addr_valid = 0;
  logic        ld_req = 0, st_commit = 0, flush_valid = 0;
  logic [2:0]  addr_idx = 0, flush_idx = 0, alloc_idx, cache_tag;
  logic [31:0] addr_val = 0, cache_addr;
  logic        full, cache_valid, cache_we;
  int total = 0, bad = 0;
  int t;

  lsq_disambig dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic nxt;
    @(posedge clk); #1;
    alloc_valid = 0; addr_valid = 0; ld_req = 0; st_commit = 0; flush_valid = 0;
  endtask

  task automatic put(input int idx, input logic [31:0] a);
    addr_valid = 1; addr_idx = 3'(idx); addr_val = a; nxt;
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    nxt; nxt; rst_n = 1;
    ld_req = 1; st_commit = 1; #2;
    chk("R1 empty full", full, 0);
    chk("R1 empty idx", alloc_idx, 0);
    chk("R1 no request", cache_valid, 0);
    nxt;

    // scenario A: L0, S1, L2
    alloc_valid = 1; alloc_is_store = 0; #2 chk("R2 idx0", alloc_idx, 0); nxt;
    alloc_valid = 1; alloc_is_store = 1; #2 chk("R2 idx1", alloc_idx, 1); nxt;
    alloc_valid = 1; alloc_is_store = 0; #2 chk("R2 idx2", alloc_idx, 2); nxt;
    ld_req = 1; #2 chk("R10 no address no grant", cache_valid, 0); nxt;
    put(2, 32'h100);
    ld_req = 1; #2 chk("R3 unknown older store blocks", cache_valid, 0); nxt;
    put(0, 32'h100);
    ld_req = 1; #2;
    chk("R5 younger store ignored", cache_valid, 1);
    chk("R5 grant tag", cache_tag, 0);
    chk("R5 read", cache_we, 0);
    nxt;
    ld_req = 1; #2 chk("R3 still blocked", cache_valid, 0); nxt;
    put(1, 32'h102);
    ld_req = 1; #2 chk("R4 same word blocks", cache_valid, 0); nxt;
    st_commit = 1; ld_req = 1; #2;
    chk("R7 store sent", cache_valid, 1);
    chk("R7 write", cache_we, 1);
    chk("R7 tag", cache_tag, 1);
    chk("R7 addr", cache_addr, 32'h102);
    nxt;
    ld_req = 1; #2;
    chk("R9 load freed after store retires", cache_valid, 1);
    chk("R9 tag", cache_tag, 2);
    chk("R9 addr", cache_addr, 32'h100);
    nxt; nxt;

    // scenario B: store priority, S3 L4
    alloc_valid = 1; alloc_is_store = 1; #2 chk("R2 idx3", alloc_idx, 3); nxt;
    alloc_valid = 1; alloc_is_store = 0; nxt;
    put(3, 32'h400);
    put(4, 32'h500);
    st_commit = 1; ld_req = 1; #2;
    chk("R7 store over load", cache_we, 1);
    chk("R7 priority tag", cache_tag, 3);
    nxt;
    ld_req = 1; #2 chk("R6 load after store", cache_tag, 4); chk("R6 valid", cache_valid, 1); nxt;
    ld_req = 1; #2 chk("R6 granted once", cache_valid, 0); nxt;
    t = 5;

    // sweep load offset against store at 0x200
    for (int off = 0; off < 8; off++) begin
      int s, l;
      s = t; l = (t + 1) % 8;
      alloc_valid = 1; alloc_is_store = 1; #2 chk("R2 store slot", alloc_idx, s); nxt;
      alloc_valid = 1; alloc_is_store = 0; #2 chk("R2 load slot", alloc_idx, l); nxt;
      st_commit = 1; #2 chk("R7 no address held", cache_valid, 0); nxt;
      put(s, 32'h200);
      put(l, 32'h200 + off);
      ld_req = 1; #2;
      chk("R4 word compare", cache_valid, (off >= 4) ? 1 : 0);
      if (off >= 4) chk("R4 grant tag", cache_tag, l);
      nxt;
      flush_valid = 1; flush_idx = 3'(s); ld_req = 1; #2 chk("R8 no request on flush", cache_valid, 0); nxt;
      #2 chk("R8 tail after flush", alloc_idx, (s + 1) % 8);
      st_commit = 1; ld_req = 1; #2;
      chk("R7 commit sends store", cache_valid, 1);
      chk("R7 commit write", cache_we, 1);
      chk("R7 commit tag", cache_tag, s);
      chk("R7 commit addr", cache_addr, 32'h200);
      nxt;
      ld_req = 1; #2 chk("R8 flushed load gone", cache_valid, 0); nxt;
      t = (t + 1) % 8;
    end

    // fill, overflow attempt, oldest-first drain across wrap
    for (int k = 0; k < 8; k++) begin
      alloc_valid = 1; alloc_is_store = 0; #2 chk("R2 fill slot", alloc_idx, (t + k) % 8); nxt;
    end
    #2 chk("R2 full", full, 1);
    alloc_valid = 1; #2 chk("R2 idx held when full", alloc_idx, t); nxt;
    #2 chk("R2 still full", full, 1);
    chk("R2 idx unchanged", alloc_idx, t);
    for (int k = 7; k >= 0; k--) put((t + k) % 8, 32'h1000 + 32'(k) * 4);
    #2 chk("R6 no grant without request", cache_valid, 0);
    for (int k = 0; k < 8; k++) begin
      ld_req = 1; #2;
      chk("R6 oldest first valid", cache_valid, 1);
      chk("R6 oldest first tag", cache_tag, (t + k) % 8);
      chk("R6 oldest first addr", cache_addr, 32'h1000 + 32'(k) * 4);
      nxt;
    end
    nxt;
    #2 chk("R9 drained", full, 0);
    ld_req = 1; #2 chk("R6 nothing left", cache_valid, 0);
    nxt;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule